// File: doc/BRIEF.md
# Interrupt Controller Command Interface

This block is the byte-wide programming front end of an eight-line priority interrupt controller. Each controller has two address positions. Writes to position 0 carry the initialization start word, the read/poll/special-mask control word, and the end-of-interrupt and rotation commands. Writes to position 1 are interpreted according to where the initialization sequence currently is: vector base, a pass-through word, an optional mode word, or (once the sequence has finished) the line mask. Reads return the pending-request bits, the in-service bits or the mask. While a poll is armed, a read returns a poll byte instead.

The priority resolver is a separate block. It supplies its request, in-service and poll bytes as inputs. The interface drives it with the mask, the mode bits and the rotation base, plus single-cycle strobes: one for initialization and one for clearing an in-service line. For non-specific end-of-interrupt commands the interface itself picks the highest-priority in-service line. The search starts at the rotation base and wraps around, so the resolver only ever receives a specific line to clear.

Top module: `irqc_cmd_if`

## Requirements
- R1: After reset the mask, vector base, rotation base and every mode bit are zero, the interface is in normal (non-initializing) state, no strobe is high, and a read at address 0 returns the request byte.
- R2: A write takes effect only when `wr_en` and `byte_vld` are both high; a write with `byte_vld` low changes no state and raises no strobe.
- R3: A write at address 0 with bit 4 set starts initialization. It latches the four-word flag from bit 0 and clears the mask, rotation base, special mask and read select. It pulses `init_stb` so the resolver can drop edge-mode requests. When bit 0 is 0, it also clears auto-EOI and nested mode.
- R4: After the start word, the first address-1 write sets the vector base to bits 7:3. The second ends the sequence unless the four-word flag is set. In that case the third sets nested mode from bit 4 and auto-EOI from bit 1 and ends the sequence.
- R5: In normal state an address-1 write loads the line mask.
- R6: An address-0 write with bit 4 clear and bit 3 set is a control word. Bit 2 set arms poll. Bit 1 set loads read select from bit 0. Bit 6 set loads special mask from bit 5. A cleared enable bit leaves its field unchanged.
- R7: An address-0 write with bits 4 and 3 clear is a command in bits 7:5. Code 0 clears and code 4 sets rotate-on-auto-EOI. Code 6 sets the rotation base to (bits 2:0 + 1) mod 8. Code 2 changes nothing.
- R8: Code 3 (specific EOI) clears line bits 2:0. Code 7 does the same and also sets the rotation base to that line + 1 mod 8.
- R9: Code 1 (non-specific EOI) clears the first set in-service line found searching upward from the rotation base with wrap. Code 5 does the same and also sets the rotation base to that line + 1 mod 8. With no in-service line, neither code strobes or changes the rotation base.
- R10: With no poll armed, a read at address 0 returns the in-service byte if read select is 1 and the request byte otherwise, and a read at address 1 returns the mask. While poll is armed, both addresses return the poll byte. `poll_ack` is high for the read, and the poll is disarmed after it; a poll-arming write in the same cycle wins.
- R11: `init_stb` and `clr_stb` are high for exactly the one cycle after the accepted write that causes them, with `clr_line` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| byte_vld | input | 1 | Write byte qualifier |
| rd_en | input | 1 | Read request (consumes an armed poll) |
| addr | input | 1 | Address position within the controller |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| req_bits | input | 8 | Pending-request byte from the resolver |
| svc_bits | input | 8 | In-service byte from the resolver |
| poll_byte | input | 8 | Poll result byte from the resolver |
| poll_ack | output | 1 | A read consumed the armed poll |
| line_mask | output | 8 | Line mask |
| vec_base | output | 5 | Vector base |
| auto_eoi | output | 1 | Automatic EOI mode |
| nest_mode | output | 1 | Special nested mode |
| rot_on_auto | output | 1 | Rotate on automatic EOI |
| spec_mask | output | 1 | Special mask mode |
| prio_base | output | 3 | Lowest-numbered line of the current priority order |
| init_stb | output | 1 | Initialization strobe |
| clr_stb | output | 1 | In-service clear strobe |
| clr_line | output | 3 | Line to clear |

## Verification
The bench builds the block with its default eight lines and eight-bit data. At that size all eight rotation bases are reachable, so the wrap from line 7 to line 0 is exercised in both the code-6 rotation and the non-specific search. A behavioural model kept in integers is compared with every output on every clock. Directed sequences cover both initialization lengths, each command code and an empty in-service byte. A long random phase then mixes unqualified writes, overlapping reads and poll arming.

// File: rtl/irqc_cmd_if.sv
module irqc_cmd_if #(
  parameter int LINES = 8,
  parameter int DW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              byte_vld,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [LINES-1:0]  req_bits,
  input  logic [LINES-1:0]  svc_bits,
  input  logic [DW-1:0]     poll_byte,
  output logic              poll_ack,
  output logic [LINES-1:0]  line_mask,
  output logic [DW-$clog2(LINES)-1:0] vec_base,
  output logic              auto_eoi,
  output logic              nest_mode,
  output logic              rot_on_auto,
  output logic              spec_mask,
  output logic [$clog2(LINES)-1:0] prio_base,
  output logic              init_stb,
  output logic              clr_stb,
  output logic [$clog2(LINES)-1:0] clr_line
);
  localparam int LW = $clog2(LINES);

  typedef enum logic [1:0] {S_RUN, S_BASE, S_WORD3, S_WORD4} seq_t;

  seq_t seq;
  logic need4, rd_svc, poll_q;

  wire acc    = wr_en & byte_vld;
  wire w_ctl  = acc & ~addr;
  wire w_dat  = acc & addr;
  wire w_init = w_ctl & wdata[4];
  wire w_sel  = w_ctl & ~wdata[4] & wdata[3];
  wire w_cmd  = w_ctl & ~wdata[4] & ~wdata[3];
  wire [2:0]    code = wdata[7:5];
  wire [LW-1:0] arg  = wdata[LW-1:0];

  logic          hit;
  logic [LW-1:0] top;

  always_comb begin
    hit = 1'b0;
    top = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      if (svc_bits[LW'((int'(prio_base) + k) % LINES)]) begin
        hit = 1'b1;
        top = LW'((int'(prio_base) + k) % LINES);
      end
    end
  end

  assign poll_ack = rd_en & poll_q;
  assign rdata = poll_q ? poll_byte :
                 addr   ? DW'(line_mask) :
                 rd_svc ? DW'(svc_bits) : DW'(req_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq         <= S_RUN;
      need4       <= 1'b0;
      rd_svc      <= 1'b0;
      poll_q      <= 1'b0;
      line_mask   <= '0;
      vec_base    <= '0;
      auto_eoi    <= 1'b0;
      nest_mode   <= 1'b0;
      rot_on_auto <= 1'b0;
      spec_mask   <= 1'b0;
      prio_base   <= '0;
      init_stb    <= 1'b0;
      clr_stb     <= 1'b0;
      clr_line    <= '0;
    end else begin
      init_stb <= w_init;
      clr_stb  <= 1'b0;

      if (w_init) begin
        need4     <= wdata[0];
        line_mask <= '0;
        prio_base <= '0;
        spec_mask <= 1'b0;
        rd_svc    <= 1'b0;
        seq       <= S_BASE;
        if (!wdata[0]) begin
          auto_eoi  <= 1'b0;
          nest_mode <= 1'b0;
        end
      end

      if (w_dat) begin
        case (seq)
          S_RUN:   line_mask <= wdata[LINES-1:0];
          S_BASE:  begin
            vec_base <= wdata[DW-1:LW];
            seq      <= S_WORD3;
          end
          S_WORD3: seq <= need4 ? S_WORD4 : S_RUN;
          S_WORD4: begin
            nest_mode <= wdata[4];
            auto_eoi  <= wdata[1];
            seq       <= S_RUN;
          end
          default: seq <= S_RUN;
        endcase
      end

      if (w_sel) begin
        if (wdata[1]) rd_svc    <= wdata[0];
        if (wdata[6]) spec_mask <= wdata[5];
      end

      if (w_sel && wdata[2])   poll_q <= 1'b1;
      else if (rd_en && poll_q) poll_q <= 1'b0;

      if (w_cmd) begin
        case (code)
          3'd0, 3'd4: rot_on_auto <= code[2];
          3'd1: if (hit) begin
            clr_stb  <= 1'b1;
            clr_line <= top;
          end
          3'd5: if (hit) begin
            clr_stb   <= 1'b1;
            clr_line  <= top;
            prio_base <= LW'(top + 1'b1);
          end
          3'd3: begin
            clr_stb  <= 1'b1;
            clr_line <= arg;
          end
          3'd6: prio_base <= LW'(arg + 1'b1);
          3'd7: begin
            clr_stb   <= 1'b1;
            clr_line  <= arg;
            prio_base <= LW'(arg + 1'b1);
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_unqualified_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && byte_vld) |=> ($stable(line_mask) && $stable(vec_base) && $stable(prio_base) && !init_stb && !clr_stb));

  a_r3_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && byte_vld && !addr && wdata[4]) |=> (line_mask == '0 && prio_base == '0 && !spec_mask && init_stb));

  a_r4_word4_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (seq == S_WORD4 && wr_en && byte_vld && addr) |=> (seq == S_RUN));

  a_r10_poll_once: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && poll_q && !(w_sel && wdata[2])) |=> !poll_q);

  a_r11_clr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |-> $past(wr_en && byte_vld && !addr && !wdata[4] && !wdata[3]));

  a_r11_init_cause: assert property (@(posedge clk) disable iff (!rst_n)
    init_stb |-> $past(wr_en && byte_vld && !addr && wdata[4]));
endmodule

// File: tb/irqc_cmd_if_tb.sv
module irqc_cmd_if_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, byte_vld = 0, rd_en = 0, addr = 0;
  logic [7:0] wdata = 0, req_bits = 0, svc_bits = 0, poll_byte = 0;
  logic [7:0] rdata, line_mask;
  logic [4:0] vec_base;
  logic [2:0] prio_base, clr_line;
  logic poll_ack, auto_eoi, nest_mode, rot_on_auto, spec_mask, init_stb, clr_stb;

  int compared = 0, mismatched = 0;
  bit done = 0;

  int m_mask, m_base, m_st, m_need4, m_aeoi, m_nest, m_rota, m_smask, m_rsel, m_poll, m_prio, m_init, m_clr, m_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_cmd_if u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .byte_vld(byte_vld), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .req_bits(req_bits), .svc_bits(svc_bits),
    .poll_byte(poll_byte), .poll_ack(poll_ack), .line_mask(line_mask), .vec_base(vec_base),
    .auto_eoi(auto_eoi), .nest_mode(nest_mode), .rot_on_auto(rot_on_auto),
    .spec_mask(spec_mask), .prio_base(prio_base), .init_stb(init_stb),
    .clr_stb(clr_stb), .clr_line(clr_line)
  );

  task automatic chk(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mask = 0; m_base = 0; m_st = 0; m_need4 = 0; m_aeoi = 0; m_nest = 0; m_rota = 0;
    m_smask = 0; m_rsel = 0; m_poll = 0; m_prio = 0; m_init = 0; m_clr = 0; m_line = 0;
  endtask

  function automatic int exp_rdata();
    if (m_poll != 0) return int'(poll_byte);
    if (addr) return m_mask;
    return (m_rsel != 0) ? int'(svc_bits) : int'(req_bits);
  endfunction

  task automatic model_edge();
    int d, c, found, ln;
    bit acc;
    d = int'(wdata);
    acc = wr_en && byte_vld;
    m_init = 0;
    m_clr = 0;
    if (m_poll != 0 && rd_en) m_poll = 0;
    if (acc && addr) begin
      if (m_st == 0) m_mask = d;
      else if (m_st == 1) begin m_base = d / 8; m_st = 2; end
      else if (m_st == 2) m_st = (m_need4 != 0) ? 3 : 0;
      else begin m_nest = (d >> 4) & 1; m_aeoi = (d >> 1) & 1; m_st = 0; end
    end else if (acc && ((d & 16) != 0)) begin
      m_init = 1; m_need4 = d & 1; m_mask = 0; m_prio = 0; m_smask = 0; m_rsel = 0; m_st = 1;
      if (m_need4 == 0) begin m_aeoi = 0; m_nest = 0; end
    end else if (acc && ((d & 8) != 0)) begin
      if ((d & 2) != 0) m_rsel = d & 1;
      if ((d & 64) != 0) m_smask = (d >> 5) & 1;
      if ((d & 4) != 0) m_poll = 1;
    end else if (acc) begin
      c = d >> 5;
      found = -1;
      for (int k = 0; k < 8; k++) begin
        ln = (m_prio + k) % 8;
        if (found < 0 && svc_bits[ln]) found = ln;
      end
      case (c)
        0: m_rota = 0;
        4: m_rota = 1;
        1, 5: if (found >= 0) begin
          m_clr = 1; m_line = found;
          if (c == 5) m_prio = (found + 1) % 8;
        end
        3: begin m_clr = 1; m_line = d % 8; end
        6: m_prio = (d % 8 + 1) % 8;
        7: begin m_clr = 1; m_line = d % 8; m_prio = (d % 8 + 1) % 8; end
        default: ;
      endcase
    end
  endtask

  task automatic compare_regs();
    chk("R5 line_mask", int'(line_mask), m_mask);
    chk("R4 vec_base", int'(vec_base), m_base);
    chk("R4 auto_eoi", int'(auto_eoi), m_aeoi);
    chk("R4 nest_mode", int'(nest_mode), m_nest);
    chk("R7 rot_on_auto", int'(rot_on_auto), m_rota);
    chk("R6 spec_mask", int'(spec_mask), m_smask);
    chk("R7 prio_base", int'(prio_base), m_prio);
    chk("R11 init_stb", int'(init_stb), m_init);
    chk("R11 clr_stb", int'(clr_stb), m_clr);
    if (m_clr != 0) chk("R9 clr_line", int'(clr_line), m_line);
  endtask

  task automatic step();
    #1;
    chk("R10 rdata", int'(rdata), exp_rdata());
    chk("R10 poll_ack", int'(poll_ack), (rd_en && m_poll != 0) ? 1 : 0);
    @(posedge clk);
    if (rst_n) model_edge(); else model_reset();
    #2;
    compare_regs();
  endtask

  task automatic idle();
    wr_en = 0; byte_vld = 0; rd_en = 0;
  endtask

  task automatic wr(logic a, logic [7:0] d, logic bv = 1'b1);
    wr_en = 1; byte_vld = bv; rd_en = 0; addr = a; wdata = d;
    step();
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    model_reset();
    req_bits = 8'h3C;
    @(negedge clk);
    repeat (3) step();
    rst_n = 1;
    step();
    // R1: reset state
    chk("R1 mask", int'(line_mask), 0);
    chk("R1 modes", int'({auto_eoi, nest_mode, rot_on_auto, spec_mask}), 0);
    addr = 0; #1 chk("R1 read request byte", int'(rdata), 8'h3C);

    wr(1, 8'hA5, 1'b0);
    chk("R2 unqualified write ignored", int'(line_mask), 0);
    wr(1, 8'hA5);
    chk("R5 mask load", int'(line_mask), 8'hA5);
    addr = 1; #1 chk("R10 read mask", int'(rdata), 8'hA5);

    wr(0, 8'h11);
    chk("R3 init clears mask", int'(line_mask), 0);
    chk("R11 init strobe high", int'(init_stb), 1);
    step();
    chk("R11 init strobe one cycle", int'(init_stb), 0);
    wr(1, 8'h48);
    chk("R4 vector base", int'(vec_base), 9);
    wr(1, 8'h00);
    wr(1, 8'h12);
    chk("R4 nested from word 4", int'(nest_mode), 1);
    chk("R4 auto-eoi from word 4", int'(auto_eoi), 1);
    wr(1, 8'h3C);
    chk("R4 back to mask", int'(line_mask), 8'h3C);

    wr(0, 8'h10);
    chk("R3 short init clears modes", int'({auto_eoi, nest_mode}), 0);
    wr(1, 8'hF8);
    chk("R4 vector base max", int'(vec_base), 31);
    wr(1, 8'h00);
    wr(1, 8'h0F);
    chk("R4 three-word sequence ends", int'(line_mask), 8'h0F);

    svc_bits = 8'h81;
    wr(0, 8'h0B);
    addr = 0; #1 chk("R6 read select in-service", int'(rdata), 8'h81);
    wr(0, 8'h09);
    addr = 0; #1 chk("R6 select unchanged w/o enable", int'(rdata), 8'h81);
    wr(0, 8'h0A);
    addr = 0; #1 chk("R10 read request", int'(rdata), 8'h3C);
    wr(0, 8'h68);
    chk("R6 special mask set", int'(spec_mask), 1);
    wr(0, 8'h28);
    chk("R6 special mask kept", int'(spec_mask), 1);
    wr(0, 8'h48);
    chk("R6 special mask clear", int'(spec_mask), 0);

    poll_byte = 8'h85;
    wr(0, 8'h0C);
    addr = 1; #1 chk("R10 poll byte", int'(rdata), 8'h85);
    rd_en = 1; #1 chk("R10 poll ack", int'(poll_ack), 1);
    step();
    idle();
    addr = 1; #1 chk("R10 poll disarmed", int'(rdata), 8'h0F);

    wr(0, 8'h80);
    chk("R7 rotate-on-auto set", int'(rot_on_auto), 1);
    wr(0, 8'h40);
    chk("R7 code 2 no strobe", int'(clr_stb), 0);
    chk("R7 code 2 keeps state", int'({rot_on_auto, prio_base}), 8);
    wr(0, 8'h00);
    chk("R7 rotate-on-auto clear", int'(rot_on_auto), 0);
    wr(0, 8'hC3);
    chk("R7 set priority", int'(prio_base), 4);
    wr(0, 8'hC7);
    chk("R7 priority wrap", int'(prio_base), 0);

    wr(0, 8'h65);
    chk("R8 specific eoi strobe", int'(clr_stb), 1);
    chk("R8 specific eoi line", int'(clr_line), 5);
    wr(0, 8'hE6);
    chk("R8 rotating specific line", int'(clr_line), 6);
    chk("R8 rotating specific prio", int'(prio_base), 7);

    wr(0, 8'h20);
    chk("R9 wrap search line", int'(clr_line), 7);
    wr(0, 8'hC7);
    wr(0, 8'h20);
    chk("R9 search from base 0", int'(clr_line), 0);
    svc_bits = 8'h00;
    wr(0, 8'h20);
    chk("R9 empty no strobe", int'(clr_stb), 0);
    wr(0, 8'hA0);
    chk("R9 empty rotating no strobe", int'(clr_stb), 0);
    chk("R9 empty keeps prio", int'(prio_base), 0);
    svc_bits = 8'h14;
    wr(0, 8'hC5);
    wr(0, 8'hA0);
    chk("R9 rotating line", int'(clr_line), 2);
    chk("R9 rotating prio", int'(prio_base), 3);

    for (int i = 0; i < 3000; i++) begin
      wr_en    = ($urandom % 2) == 0;
      byte_vld = ($urandom % 4) != 0;
      rd_en    = ($urandom % 3) == 0;
      addr     = $urandom % 2;
      wdata    = 8'($urandom);
      req_bits = 8'($urandom);
      svc_bits = (($urandom % 5) == 0) ? 8'h00 : 8'($urandom);
      poll_byte = 8'($urandom);
      step();
    end
    idle();
    step();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule